// File: doc/BRIEF.md
# Reconfigurable LUT Logic Tile

This block is a single square logic cell for a nearest-neighbour reconfigurable array. It has one 1-bit data input and one 1-bit data output on each of its four sides. Each output has its own datapath: a 3-input look-up table and three 8-way source selectors. A mode bit chooses whether that output comes straight from the table or one main-clock cycle later through an output register. The array has no routing fabric, so a tile does the wiring as well as the logic. One side can pass a neighbour's bit straight across while the other sides compute functions of the inputs or of the tile's own output registers.

Every side input is registered on the main clock before any selector sees it, so each hop through a tile adds a fixed latency. The four 18-bit configuration words are loaded through a small write port on a separate configuration clock. Each write supplies a direction code and a full word. A single active-low asynchronous reset clears both domains.

Top module: `lut_tile`

## Requirements
- R1: Each bit of `din` (bit 0 north, 1 south, 2 west, 3 east) is captured in an input register on the rising edge of `clk` before it reaches any selector. A direct-mode output therefore follows a changed input after exactly one rising `clk` edge.
- R2: Bit 17 of a datapath's configuration word sets its output mode. 0 drives the table output directly. 1 drives the output register, which delays the result by one more `clk` edge, two edges after the input change.
- R3: Each 3-bit selector field picks its source by this code: 000 north input, 001 south input, 010 west input, 011 east input, 100 north state, 101 south state, 110 west state, 111 east state. Inputs are the registered `din` bits.
- R4: Selector 2 is bits 16:14, selector 1 is bits 13:11 and selector 0 is bits 10:8. The table index is {selector 2 value, selector 1 value, selector 0 value}, and the result is bit [index] of the truth table in bits 7:0.
- R5: The state sources are the four output registers. Each one loads its table output on every `clk` edge, whatever its mode bit says. A state source can therefore feed its own table, which makes a toggle, and it can feed another datapath that is in direct mode.
- R6: On a rising `cfg_clk` edge with `cfg_we` high, `cfg_data` replaces the word of the datapath addressed by `cfg_dir` (00 north, 01 south, 10 west, 11 east). The other three words stay unchanged. With `cfg_we` low, no word changes.
- R7: While `rst_n` is low, all configuration words, input registers and output registers are zero. All outputs are 0, and they remain 0 after release until a word is written.
- R8: The four datapaths work independently. A pass-through on one side and a function on another side give correct results in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main data clock |
| cfg_clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cfg_we | input | 1 | Configuration write enable |
| cfg_dir | input | 2 | Datapath addressed by the write |
| cfg_data | input | 18 | Configuration word to store |
| din | input | 4 | Side inputs {east, west, south, north} |
| dout | output | 4 | Side outputs {east, west, south, north} |

## Verification
A configuration write can arrive in the same cycle as live data moving through a different datapath of the tile. The bench provokes this by rewriting the north word, and later presenting a write with the enable low, while a west-to-east pass-through keeps streaming a changing pattern. Each east sample is judged against the west value driven one edge earlier. The bench also checks that the rewrite of north took effect and that the disabled write left north unchanged.

// File: rtl/lut_tile.sv
module lut_tile #(
  parameter int SIDES  = 4,
  parameter int LUT_IN = 3
) (
  input  logic                 clk,
  input  logic                 cfg_clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_dir,
  input  logic [17:0]          cfg_data,
  input  logic [SIDES-1:0]     din,
  output logic [SIDES-1:0]     dout
);
  localparam int SRC_W = 2 * SIDES;
  localparam int SEL_W = $clog2(SRC_W);
  localparam int TBL_W = 1 << LUT_IN;
  localparam int CFG_W = 1 + LUT_IN * SEL_W + TBL_W;

  logic [SIDES-1:0][CFG_W-1:0] cfg;
  logic [SIDES-1:0]            in_q;
  logic [SIDES-1:0]            st_q;
  logic [SIDES-1:0]            lut_out;
  logic [SRC_W-1:0]            src;

  assign src = {st_q, in_q};

  always_ff @(posedge cfg_clk or negedge rst_n)
    if (!rst_n)      cfg <= '0;
    else if (cfg_we) cfg[cfg_dir] <= cfg_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_q <= '0;
      st_q <= '0;
    end else begin
      in_q <= din;
      st_q <= lut_out;
    end

  for (genvar d = 0; d < SIDES; d++) begin : g_path
    logic [LUT_IN-1:0] idx;
    logic [TBL_W-1:0]  tbl;
    assign tbl = cfg[d][TBL_W-1:0];
    for (genvar k = 0; k < LUT_IN; k++) begin : g_sel
      assign idx[k] = src[cfg[d][TBL_W + k*SEL_W +: SEL_W]];
    end
    assign lut_out[d] = tbl[idx];
    assign dout[d]    = cfg[d][CFG_W-1] ? st_q[d] : lut_out[d];
  end
endmodule

// File: rtl/lut_tile_chk.sv
module lut_tile_chk #(
  parameter int SIDES = 4,
  parameter int CFG_W = 18
) (
  input logic                        clk,
  input logic                        cfg_clk,
  input logic                        rst_n,
  input logic                        cfg_we,
  input logic [1:0]                  cfg_dir,
  input logic [CFG_W-1:0]            cfg_data,
  input logic [SIDES-1:0]            din,
  input logic [SIDES-1:0]            dout,
  input logic [SIDES-1:0]            in_q,
  input logic [SIDES-1:0]            st_q,
  input logic [SIDES-1:0]            lut_out,
  input logic [SIDES-1:0][CFG_W-1:0] cfg
);
  // R1
  in_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_q == $past(din));

  // R5
  state_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> st_q == $past(lut_out));

  // R7
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> dout == '0);

  for (genvar d = 0; d < SIDES; d++) begin : g_d
    // R2
    reg_mode_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && cfg[d][CFG_W-1] |-> dout[d] == $past(lut_out[d]));

    // R6
    cfg_write_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      $past(rst_n) && $past(cfg_we) && $past(cfg_dir) == d |-> cfg[d] == $past(cfg_data));

    // R6
    cfg_hold_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      $past(rst_n) && !($past(cfg_we) && $past(cfg_dir) == d) |-> $stable(cfg[d]));
  end
endmodule

bind lut_tile lut_tile_chk #(.SIDES(SIDES), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .cfg_clk(cfg_clk), .rst_n(rst_n), .cfg_we(cfg_we),
  .cfg_dir(cfg_dir), .cfg_data(cfg_data), .din(din), .dout(dout),
  .in_q(in_q), .st_q(st_q), .lut_out(lut_out), .cfg(cfg)
);

// File: tb/lut_tile_bench.sv
module lut_tile_bench;
  localparam logic [1:0] N = 2'd0, S = 2'd1, W = 2'd2, E = 2'd3;

  logic        clk = 0, cfg_clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_dir = '0;
  logic [17:0] cfg_data = '0;
  logic [3:0]  din = '0;
  logic [3:0]  dout;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;
  always #5 cfg_clk = ~cfg_clk;

  lut_tile u_lut_tile (.*);

  function automatic logic [17:0] word(input logic rg, input logic [2:0] s2,
      input logic [2:0] s1, input logic [2:0] s0, input logic [7:0] tbl);
    return {rg, s2, s1, s0, tbl};
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] dir, input logic [17:0] data, input logic we);
    @(negedge cfg_clk);
    cfg_we = we; cfg_dir = dir; cfg_data = data;
    @(negedge cfg_clk);
    cfg_we = 0; cfg_data = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 0; din = 4'hF;
    repeat (3) @(negedge clk);
    for (int d = 0; d < 4; d++) check("R7 reset low", dout[d], 1'b0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    for (int d = 0; d < 4; d++) check("R7 after release", dout[d], 1'b0);
    din = '0;
    repeat (2) @(negedge clk);
  endtask

  // east: pass of west input (R3 code 010), north: registered XOR of S,W,E (R2, R4, R8)
  task automatic t_pass_and_xor;
    logic prev_x = 0;
    cfg_write(E, word(1'b0, 3'b010, 3'b010, 3'b010, 8'hAA), 1'b1);
    cfg_write(N, word(1'b1, 3'b001, 3'b010, 3'b011, 8'h96), 1'b1);
    din = '0;
    repeat (3) @(negedge clk);
    for (int v = 0; v < 8; v++) begin
      logic x;
      din = {v[0], v[1], v[2], 1'b0};
      x = v[0] ^ v[1] ^ v[2];
      check("R1 before edge", dout[E], (v == 0) ? 1'b0 : (((v-1) >> 1) & 1) != 0);
      @(negedge clk);
      check("R1 direct one edge", dout[E], v[1]);
      check("R2 registered not yet", dout[N], prev_x);
      @(negedge clk);
      check("R8 xor two edges", dout[N], x);
      check("R8 pass held", dout[E], v[1]);
      prev_x = x;
    end
  endtask

  // west: 1 only at index 4 = {N=1, S=0, E=0} (R4 order)
  task automatic t_index_order;
    cfg_write(W, word(1'b0, 3'b000, 3'b001, 3'b011, 8'h10), 1'b1);
    for (int v = 0; v < 8; v++) begin
      din = {v[0], 1'b0, v[1], v[2]};
      @(negedge clk);
      check("R4 index order", dout[W], v == 4);
    end
  endtask

  // south: registered toggle from its own state (R5)
  task automatic t_toggle;
    logic first;
    cfg_write(S, word(1'b1, 3'b101, 3'b101, 3'b101, 8'h55), 1'b1);
    first = dout[S];
    for (int i = 1; i < 7; i++) begin
      @(negedge clk);
      check("R5 toggle", dout[S], first ^ i[0]);
    end
  endtask

  // west direct pass of east input, south direct pass of west state (R5)
  task automatic t_state_chain;
    cfg_write(W, word(1'b0, 3'b011, 3'b011, 3'b011, 8'hAA), 1'b1);
    cfg_write(S, word(1'b0, 3'b110, 3'b110, 3'b110, 8'hAA), 1'b1);
    din = '0;
    repeat (3) @(negedge clk);
    din[E] = 1;
    @(negedge clk);
    check("R5 direct west", dout[W], 1'b1);
    check("R5 state not yet", dout[S], 1'b0);
    @(negedge clk);
    check("R5 state of direct path", dout[S], 1'b1);
  endtask

  // north rewrite and a disabled write while east streams (R6)
  task automatic t_cfg_overlap;
    logic [17:0] const_one;
    const_one = word(1'b0, 3'b000, 3'b000, 3'b000, 8'hFF);
    fork
      begin
        cfg_write(N, const_one, 1'b1);
        cfg_write(N, 18'h0, 1'b0);
      end
      begin
        for (int i = 0; i < 12; i++) begin
          logic b;
          b = (i % 3) != 1;
          din[W] = b;
          @(negedge clk);
          check("R6 stream during write", dout[E], b);
        end
      end
    join
    check("R6 addressed word", dout[N], 1'b1);
    check("R6 disabled write", dout[N], 1'b1);
  endtask

  initial begin
    t_reset;
    t_pass_and_xor;
    t_index_order;
    t_toggle;
    t_state_chain;
    t_cfg_overlap;
    t_reset;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule